// File: doc/BRIEF.md
# Loopback UART Register Model

This block is a byte-wide register file of eight offsets that presents the programming model of a 16550-style serial controller with no serial line behind it. Every byte the host writes to the transmit holding register drops straight into a 16-entry receive queue, and the host drains the queue through the receive buffer register. It suits driver bring-up and virtualisation tests, where software needs a serial port that behaves like one without a wire, a baud clock or a far-end partner.

The host side is a plain synchronous bus: a 3-bit offset, a write strobe, a read strobe, write data and read data. Read data is registered and appears in the cycle after the read strobe. A single interrupt line pulses for one clock whenever an enabled event happens: a register write, a queue fill, an overflow or a queue drain. The divisor latch, queue control, interrupt identification, line status, modem status and scratch registers are all modelled. Modem status is derived from queue occupancy.

Top module: `loop_uart_regs`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, interrupt identification (offset 2) reads 0xC1, modem status (offset 6) reads 0xB3, interrupt enable (offset 1) reads 0x00 and the interrupt line is low.
- R2: With line-control bit 7 clear, a write to offset 0 appends the byte to the queue and a read of offset 0 returns the oldest byte and removes it, in first-in first-out order across index wrap; a read of an empty queue returns 0x00.
- R3: A write to offset 0 when the queue holds its current maximum drops the byte, leaves the count unchanged and sets the overrun flag (line status bit 1), and pulses the interrupt if enable bit 2 is set; the next accepted write clears overrun.
- R4: Writing line control with bit 7 set zeroes the 16-bit divisor and enters latch mode; there, writes to offsets 0 and 1 OR into the low and high divisor bytes, reads of offsets 0 and 1 return them, and the queue and the interrupt enable are untouched.
- R5: A write to offset 2 with bit 1 or bit 2 set empties the queue; bit 0 of that write selects a maximum occupancy of 16 (set) or 1 (clear); the trigger level is fixed at 1.
- R6: Writing the interrupt enable with bit 1 set while the queue is empty pulses the interrupt; with data queued it does not; reads of offset 1 return only bits 3:0.
- R7: A read of offset 0 that leaves the queue empty pulses the interrupt when enable bit 1 is set, and does not pulse it when bit 1 is clear.
- R8: An accepted write to offset 0 pulses the interrupt when enable bit 0 is set and the new count equals the trigger level (1), and not on later writes.
- R9: Modem status always has bits 7, 5 and 1 set; bits 4 and 0 are also set unless modem-control bit 5 is set and the queue is at its maximum, giving 0xB3 or 0xA2.
- R10: A modem-control write pulses the interrupt when enable bit 3 is set and any of written bits 3, 1 or 0 is 1; writes to offsets 5 and 6 are ignored; modem control (offset 4), line control (offset 3) and scratch (offset 7) read back what was written.
- R11: Offset 2 reads the highest-priority enabled pending source with bits 7:6 set: overrun with enable bit 2 gives 0xC6, count at or above trigger with enable bit 0 gives 0xC4, empty queue with enable bit 1 gives 0xC2, modem-control bit 0 or 1 with enable bit 3 gives 0xC0, and nothing pending gives 0xC1.
- R12: When write and read strobes are high in the same cycle, the write is performed and the read is ignored (no dequeue, no read data update).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The bench fills the queue to all 16 entries, overflows it and drains it past the index wrap, so a design with a wrong full compare or pointer wrap would lose, duplicate or reorder bytes. It checks that overrun survives draining and clears only on the next accepted write, and that divisor-latch writes neither enqueue nor disturb the interrupt enable, which a design decoding offsets 0 and 1 without the latch bit would get wrong. Interrupt pulses are sampled on the exact cycle after each strobe, both where an enable must fire and where it must stay quiet, and the identification priority is stepped through every level. A simultaneous write and read is issued to show that the read never consumes a byte.

// File: rtl/loop_uart_pkg.sv
package loop_uart_pkg;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_IDFC = 3'd2,
        OFS_LCTL = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LSTS = 3'd5,
        OFS_MSTS = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    // interrupt enable bits
    localparam int IEN_RXD  = 0;
    localparam int IEN_TXE  = 1;
    localparam int IEN_LINE = 2;
    localparam int IEN_MDM  = 3;

    // queue control bits
    localparam int QC_ON    = 0;
    localparam int QC_CLRA  = 1;
    localparam int QC_CLRB  = 2;

    // modem control bits
    localparam int MC_DTR   = 0;
    localparam int MC_RTS   = 1;
    localparam int MC_OUT2  = 3;
    localparam int MC_AUTO  = 5;

    localparam int LC_LATCH = 7;

    // fixed trigger level of the receive queue
    localparam int TRIG_LEVEL = 1;

    // identification codes
    localparam logic [7:0] ID_LINE = 8'hC6;
    localparam logic [7:0] ID_RXD  = 8'hC4;
    localparam logic [7:0] ID_TXE  = 8'hC2;
    localparam logic [7:0] ID_MDM  = 8'hC0;
    localparam logic [7:0] ID_NONE = 8'hC1;

    // modem status constant part and flow bits
    localparam logic [7:0] MS_FIXED = 8'hA2;
    localparam logic [7:0] MS_FLOW  = 8'h11;

endpackage

// File: rtl/loop_uart_fifo.sv
module loop_uart_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         clear,
    input  logic [WIDTH-1:0]             din,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            head;
        logic [PTR_W-1:0]            tail;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.head] = din;
                st_d.head           = ptr_inc(st_q.head);
            end
            if (pop) begin
                st_d.tail = ptr_inc(st_q.tail);
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
                2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.tail];
    assign count = st_q.cnt;

endmodule

// File: rtl/loop_uart_irq_id.sv
module loop_uart_irq_id
    import loop_uart_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       overrun,
    input  logic       at_trigger,
    input  logic       q_empty,
    input  logic       mdm_line,
    output logic [7:0] ident
);
    always_comb begin
        if (ien[IEN_LINE] && overrun)        ident = ID_LINE;
        else if (ien[IEN_RXD] && at_trigger) ident = ID_RXD;
        else if (ien[IEN_TXE] && q_empty)    ident = ID_TXE;
        else if (ien[IEN_MDM] && mdm_line)   ident = ID_MDM;
        else                                 ident = ID_NONE;
    end
endmodule

// File: rtl/loop_uart_regs.sv
module loop_uart_regs
    import loop_uart_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [3:0]  ien;
        logic [7:0]  lctl;
        logic [7:0]  mctl;
        logic [7:0]  scr;
        logic        q_on;
        logic        overrun;
        logic [15:0] divisor;
        logic [7:0]  rdata;
        logic        irq;
    } regs_st_t;

    regs_st_t st_d, st_q;

    logic             q_push, q_pop, q_clear;
    logic [7:0]       q_head;
    logic [CNT_W-1:0] fifo_count;
    logic [CNT_W-1:0] max_size;
    logic             q_empty, q_full, at_trigger, latch_mode, overrun_q;
    logic [15:0]      div_q;
    logic [7:0]       ident;
    logic             do_wr, do_rd;

    loop_uart_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .clear (q_clear),
        .din   (wdata),
        .dout  (q_head),
        .count (fifo_count)
    );

    assign max_size   = st_q.q_on ? CNT_W'(DEPTH) : CNT_W'(1);
    assign q_empty    = (fifo_count == '0);
    assign q_full     = (fifo_count >= max_size);
    assign at_trigger = (fifo_count >= CNT_W'(TRIG_LEVEL));
    assign latch_mode = st_q.lctl[LC_LATCH];
    assign overrun_q  = st_q.overrun;
    assign div_q      = st_q.divisor;
    assign do_wr      = wr_en;
    assign do_rd      = rd_en & ~wr_en;

    loop_uart_irq_id u_id (
        .ien        (st_q.ien),
        .overrun    (overrun_q),
        .at_trigger (at_trigger),
        .q_empty    (q_empty),
        .mdm_line   (st_q.mctl[MC_RTS] | st_q.mctl[MC_DTR]),
        .ident      (ident)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        q_push   = 1'b0;
        q_pop    = 1'b0;
        q_clear  = 1'b0;

        if (do_wr) begin
            case (reg_ofs_e'(addr))
                OFS_DATA: begin
                    if (latch_mode) begin
                        st_d.divisor[7:0] = div_q[7:0] | wdata;
                    end else if (!q_full) begin
                        q_push       = 1'b1;
                        st_d.overrun = 1'b0;
                        if (st_q.ien[IEN_RXD] &&
                            (fifo_count + CNT_W'(1) == CNT_W'(TRIG_LEVEL)))
                            st_d.irq = 1'b1;
                    end else begin
                        st_d.overrun = 1'b1;
                        if (st_q.ien[IEN_LINE]) st_d.irq = 1'b1;
                    end
                end
                OFS_IEN: begin
                    if (latch_mode) begin
                        st_d.divisor[15:8] = div_q[15:8] | wdata;
                    end else begin
                        st_d.ien = wdata[3:0];
                        if (wdata[IEN_TXE] && q_empty) st_d.irq = 1'b1;
                    end
                end
                OFS_IDFC: begin
                    st_d.q_on = wdata[QC_ON];
                    if (wdata[QC_CLRA] || wdata[QC_CLRB]) q_clear = 1'b1;
                end
                OFS_LCTL: begin
                    st_d.lctl = wdata;
                    if (wdata[LC_LATCH]) st_d.divisor = '0;
                end
                OFS_MCTL: begin
                    st_d.mctl = wdata;
                    if (st_q.ien[IEN_MDM] &&
                        (wdata[MC_OUT2] || wdata[MC_RTS] || wdata[MC_DTR]))
                        st_d.irq = 1'b1;
                end
                OFS_SCR: st_d.scr = wdata;
                default: ;
            endcase
        end

        if (do_rd) begin
            case (reg_ofs_e'(addr))
                OFS_DATA: begin
                    if (latch_mode) begin
                        st_d.rdata = div_q[7:0];
                    end else begin
                        st_d.rdata = q_empty ? 8'h00 : q_head;
                        q_pop      = ~q_empty;
                        if (st_q.ien[IEN_TXE] && (fifo_count <= CNT_W'(1)))
                            st_d.irq = 1'b1;
                    end
                end
                OFS_IEN:  st_d.rdata = latch_mode ? div_q[15:8] : {4'h0, st_q.ien};
                OFS_IDFC: st_d.rdata = ident;
                OFS_LCTL: st_d.rdata = st_q.lctl;
                OFS_MCTL: st_d.rdata = st_q.mctl;
                OFS_LSTS: st_d.rdata = {1'b0, q_empty, q_empty, 3'b000,
                                        overrun_q, ~q_empty};
                OFS_MSTS: st_d.rdata = MS_FIXED |
                                       ((st_q.mctl[MC_AUTO] && q_full) ? 8'h00 : MS_FLOW);
                OFS_SCR:  st_d.rdata = st_q.scr;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.q_on <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign irq   = st_q.irq;

endmodule

// File: rtl/loop_uart_checker.sv
module loop_uart_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 addr,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [7:0]                 wdata,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic [$clog2(DEPTH+1)-1:0] max_size,
    input logic                       overrun,
    input logic                       dlab,
    input logic [15:0]                divisor
);
    a_r2_enqueue: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !dlab && count < max_size)
        |=> (count == $past(count) + 1'b1) && !overrun);

    a_r3_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !dlab && count >= max_size)
        |=> overrun && (count == $past(count)));

    a_r4_latch_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3 && wdata[7])
        |=> dlab && (divisor == 16'h0000));

    a_r5_queue_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && (wdata[1] || wdata[2]))
        |=> (count == '0));

    a_r12_dequeue: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd0 && !dlab && count != '0)
        |=> (count == $past(count) - 1'b1));

    a_r12_collision_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && addr == 3'd0 && !dlab)
        |=> (count >= $past(count)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> !irq);
endmodule

bind loop_uart_regs loop_uart_checker #(.DEPTH(DEPTH)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .irq      (irq),
    .count    (fifo_count),
    .max_size (max_size),
    .overrun  (overrun_q),
    .dlab     (latch_mode),
    .divisor  (div_q)
);

// File: tb/test_loop_uart_regs.sv
module test_loop_uart_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic       irq_seen;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    loop_uart_regs #(.DEPTH(16)) i_loop_uart_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        irq_seen = irq;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rd_val = rdata;
        irq_seen = irq;
    endtask

    task automatic tidy();
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h07);
        wr(3'd0, 8'h00);
        rd(3'd0);
    endtask

    task automatic t_reset();
        chk("R1 irq low", {7'd0, irq}, 8'h00);
        rd(3'd5); chk("R1 line status", rd_val, 8'h60);
        rd(3'd2); chk("R1 ident", rd_val, 8'hC1);
        rd(3'd6); chk("R1 modem status", rd_val, 8'hB3);
        rd(3'd1); chk("R1 enable", rd_val, 8'h00);
    endtask

    task automatic t_loopback();
        wr(3'd2, 8'h07);
        wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
        rd(3'd5); chk("R2 data ready", rd_val, 8'h01);
        rd(3'd0); chk("R2 first", rd_val, 8'h11);
        rd(3'd0); chk("R2 second", rd_val, 8'h22);
        rd(3'd0); chk("R2 third", rd_val, 8'h33);
        rd(3'd5); chk("R2 empty status", rd_val, 8'h60);
        rd(3'd0); chk("R2 empty read", rd_val, 8'h00);
    endtask

    task automatic t_wrap();
        wr(3'd2, 8'h07);
        for (int i = 0; i < 16; i++) wr(3'd0, 8'h40 + 8'(i));
        rd(3'd5); chk("R3 full no overrun", rd_val, 8'h01);
        wr(3'd0, 8'hEE);
        rd(3'd5); chk("R3 overrun flag", rd_val, 8'h03);
        for (int i = 0; i < 16; i++) begin
            rd(3'd0); chk("R2 wrap order", rd_val, 8'h40 + 8'(i));
        end
        rd(3'd5); chk("R3 overrun survives drain", rd_val, 8'h62);
        wr(3'd0, 8'h5A);
        rd(3'd5); chk("R3 overrun cleared", rd_val, 8'h01);
        rd(3'd0); chk("R2 after wrap", rd_val, 8'h5A);
        tidy();
    endtask

    task automatic t_overrun_irq();
        wr(3'd2, 8'h06);
        wr(3'd1, 8'h04);
        wr(3'd0, 8'h10); chk("R3 no pulse on accept", {7'd0, irq_seen}, 8'h00);
        wr(3'd0, 8'h20); chk("R3 pulse on drop", {7'd0, irq_seen}, 8'h01);
        rd(3'd5); chk("R5 depth one overrun", rd_val, 8'h03);
        rd(3'd0); chk("R3 kept byte", rd_val, 8'h10);
        tidy();
    endtask

    task automatic t_divisor();
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h12); wr(3'd1, 8'h34);
        rd(3'd0); chk("R4 low byte", rd_val, 8'h12);
        rd(3'd1); chk("R4 high byte", rd_val, 8'h34);
        wr(3'd0, 8'h01);
        rd(3'd0); chk("R4 OR into low", rd_val, 8'h13);
        rd(3'd5); chk("R4 no enqueue", rd_val, 8'h60);
        wr(3'd3, 8'h80);
        rd(3'd0); chk("R4 zeroed low", rd_val, 8'h00);
        rd(3'd1); chk("R4 zeroed high", rd_val, 8'h00);
        wr(3'd3, 8'h03);
        rd(3'd3); chk("R10 line control readback", rd_val, 8'h03);
        rd(3'd1); chk("R4 enable untouched", rd_val, 8'h00);
        tidy();
    endtask

    task automatic t_qctl();
        wr(3'd2, 8'h01);
        wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);
        wr(3'd2, 8'h03);
        rd(3'd5); chk("R5 clear bit1", rd_val, 8'h60);
        wr(3'd0, 8'hA3);
        wr(3'd2, 8'h05);
        rd(3'd5); chk("R5 clear bit2", rd_val, 8'h60);
        wr(3'd0, 8'h77);
        wr(3'd2, 8'h01);
        rd(3'd5); chk("R5 no clear keeps data", rd_val, 8'h01);
        rd(3'd0); chk("R5 kept byte", rd_val, 8'h77);
        tidy();
    endtask

    task automatic t_enable();
        wr(3'd1, 8'h02); chk("R6 pulse when empty", {7'd0, irq_seen}, 8'h01);
        wr(3'd1, 8'hF3); chk("R6 pulse again", {7'd0, irq_seen}, 8'h01);
        rd(3'd1); chk("R6 low nibble only", rd_val, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h09);
        wr(3'd1, 8'h02); chk("R6 no pulse with data", {7'd0, irq_seen}, 8'h00);
        rd(3'd0); chk("R7 pulse on drain", {7'd0, irq_seen}, 8'h01);
        tidy();
    endtask

    task automatic t_rx_irq();
        wr(3'd1, 8'h01);
        wr(3'd0, 8'hB1); chk("R8 pulse at trigger", {7'd0, irq_seen}, 8'h01);
        wr(3'd0, 8'hB2); chk("R8 no pulse above", {7'd0, irq_seen}, 8'h00);
        rd(3'd0);
        rd(3'd0); chk("R7 no pulse when disabled", {7'd0, irq_seen}, 8'h00);
        tidy();
    endtask

    task automatic t_modem_status();
        wr(3'd4, 8'h20);
        wr(3'd2, 8'h06);
        rd(3'd6); chk("R9 auto flow not full", rd_val, 8'hB3);
        wr(3'd0, 8'hC1);
        rd(3'd6); chk("R9 auto flow full", rd_val, 8'hA2);
        wr(3'd4, 8'h00);
        rd(3'd6); chk("R9 full without auto flow", rd_val, 8'hB3);
        tidy();
    endtask

    task automatic t_modem_ctl();
        wr(3'd1, 8'h08);
        wr(3'd4, 8'h08); chk("R10 out2 pulse", {7'd0, irq_seen}, 8'h01);
        wr(3'd4, 8'h02); chk("R10 rts pulse", {7'd0, irq_seen}, 8'h01);
        wr(3'd4, 8'h10); chk("R10 other bit quiet", {7'd0, irq_seen}, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h01); chk("R10 disabled quiet", {7'd0, irq_seen}, 8'h00);
        rd(3'd4); chk("R10 modem control readback", rd_val, 8'h01);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'h00);
        rd(3'd5); chk("R10 line status ignores write", rd_val, 8'h60);
        rd(3'd6); chk("R10 modem status ignores write", rd_val, 8'hB3);
        wr(3'd7, 8'hA5);
        rd(3'd7); chk("R10 scratch", rd_val, 8'hA5);
        tidy();
    endtask

    task automatic t_ident();
        wr(3'd1, 8'h0F);
        wr(3'd4, 8'h03);
        rd(3'd2); chk("R11 empty source", rd_val, 8'hC2);
        wr(3'd0, 8'hD1);
        rd(3'd2); chk("R11 data source", rd_val, 8'hC4);
        wr(3'd2, 8'h06);
        wr(3'd0, 8'hD2); wr(3'd0, 8'hD3);
        rd(3'd2); chk("R11 overrun source", rd_val, 8'hC6);
        wr(3'd2, 8'h07);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00); rd(3'd0);
        wr(3'd1, 8'h08);
        rd(3'd2); chk("R11 modem source", rd_val, 8'hC0);
        wr(3'd4, 8'h00);
        rd(3'd2); chk("R11 none", rd_val, 8'hC1);
        tidy();
    endtask

    task automatic t_collision();
        wr(3'd2, 8'h07);
        wr(3'd0, 8'h31);
        rd(3'd7);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h32; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 read data not updated", rdata, 8'h00);
        rd(3'd0); chk("R12 no dequeue", rd_val, 8'h31);
        rd(3'd0); chk("R12 write done", rd_val, 8'h32);
        rd(3'd5); chk("R12 empty after", rd_val, 8'h60);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loopback();
        t_wrap();
        t_overrun_irq();
        t_divisor();
        t_qctl();
        t_enable();
        t_rx_irq();
        t_modem_status();
        t_modem_ctl();
        t_ident();
        wr(3'd7, 8'h00);
        t_collision();
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule